// File: doc/BRIEF.md
# Framed Word Serializer

This block takes a 22-bit parallel word once per word period and sends it out one bit at a time on a single serial line. Everything runs on a bit-rate clock. A bit-enable strobe advances the serial slot. A separate capture strobe marks the parallel-clock rising edge on which the input word is latched. The bit rate is 25 times the word rate, so one complete word leaves the block in every word period. Word rates of 5 MHz to 10 MHz are the intended range.

Each transmitted frame is 25 slots long. It opens with a start slot that is always 0. The data bits follow, lowest index first. Two closing boundary slots carry the complement of the highest data bit. Because of the boundary slots, every frame contains at least one level change, and a receiver can use that change to find word edges. A word latched during one frame goes out in the next frame, which gives one word of latency.

An active-low power-down input idles the line at 0, clears the captured word and the slot position, and ignores the data inputs. When power-down is released, transmission begins with a full frame starting at the start slot.

Top module: `word_framer_ser`

## Requirements
- R1: When `pwr_n` is high and `word_ld` is high at a clock edge, all 22 bits of `din` are captured together at that edge.
- R2: Slot 0 of every frame drives `sdo` to 0.
- R3: Slots 1 to 22 carry captured data bits 0 to 21 in ascending order: slot k carries bit k-1.
- R4: Slots 23 and 24 both carry the complement of data bit 21 of the word in the frame.
- R5: The slot position advances by one only on edges where `bit_en` is high and wraps from 24 back to 0. On other edges `sdo` holds its value.
- R6: While `pwr_n` is low, `sdo` is 0 from the next edge on, the slot position and the captured word are cleared, and `word_ld`/`din` have no effect.
- R7: A word captured during frame N is sent in frame N+1. The frame content is taken at the slot-0 edge, so a capture on that same edge goes out one frame later.
- R8: The first enabled edge after `pwr_n` rises sends the start slot of a complete frame.
- R9: After reset, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_n | input | 1 | Active-low power-down |
| bit_en | input | 1 | Slot advance enable, one per bit period |
| word_ld | input | 1 | Capture strobe, one per parallel-clock rising edge |
| din | input | 22 | Parallel data word |
| sdo | output | 1 | Serial data out, registered |

## Verification
The bench builds the block with its default parameters: 22 data bits, 2 boundary slots and a two-stage reset synchronizer. That gives the 25-slot frame, so the wrap from the last boundary slot back to the start slot is crossed more than a hundred times. With gaps in `bit_en` and captures placed at random slots, including slot 0 itself, the hold behaviour, the one-frame latency and the same-edge capture ordering are all exercised. Directed all-ones, all-zeros and high-bit-only words flip the boundary polarity. Power-down is asserted in mid-frame with a capture pulsed during it, which reaches the clear path and the restart at the start slot.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    SK_LEAD = 2'd0,
    SK_DATA = 2'd1,
    SK_TAIL = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/sf_rst_sync.sv
module sf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/sf_word_latch.sv
module sf_word_latch #(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] cap
);
  logic [DATA_W-1:0] cap_q;
  logic [DATA_W-1:0] cap_d;

  always_comb begin
    cap_d = cap_q;
    if (!pwr_n)  cap_d = '0;
    else if (ld) cap_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  assign cap = cap_q;

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && !ld) |=> $stable(cap_q)); // R1
  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && ld) |=> (cap_q == $past(din))); // R1
  AST_CAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> (cap_q == '0)); // R6
endmodule

// File: rtl/sf_slot_seq.sv
module sf_slot_seq
  import sf_pkg::*;
#(
  parameter int DATA_W = 22,
  parameter int TAIL_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pwr_n,
  input  logic                        bit_en,
  output slot_kind_e                  kind,
  output logic [$clog2(DATA_W)-1:0]   data_idx
);
  localparam int FRAME_LEN = 1 + DATA_W + TAIL_W;
  localparam int SLOT_W    = $clog2(FRAME_LEN);
  localparam int IDX_W     = $clog2(DATA_W);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);
  localparam logic [SLOT_W-1:0] DATA_END  = SLOT_W'(DATA_W);

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    slot_d = slot_q;
    if (!pwr_n) begin
      slot_d = '0;
    end else if (bit_en) begin
      if (slot_q == LAST_SLOT) slot_d = '0;
      else                     slot_d = slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  always_comb begin
    if (slot_q == '0)            kind = SK_LEAD;
    else if (slot_q <= DATA_END) kind = SK_DATA;
    else                         kind = SK_TAIL;
    data_idx = IDX_W'(slot_q - SLOT_W'(1));
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && !bit_en) |=> $stable(slot_q)); // R5
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && bit_en && slot_q == LAST_SLOT) |=> (slot_q == '0)); // R5
  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= LAST_SLOT); // R5
  AST_PD_SLOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> (slot_q == '0)); // R8
endmodule

// File: rtl/sf_bit_mux.sv
module sf_bit_mux
  import sf_pkg::*;
#(
  parameter int DATA_W = 22
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pwr_n,
  input  logic                      bit_en,
  input  slot_kind_e                kind,
  input  logic [$clog2(DATA_W)-1:0] data_idx,
  input  logic [DATA_W-1:0]         cap,
  output logic                      sdo
);
  logic [DATA_W-1:0] frm_q;
  logic [DATA_W-1:0] frm_d;
  logic              out_q;
  logic              out_d;
  logic              adv;

  assign adv = pwr_n && bit_en;

  always_comb begin
    frm_d = frm_q;
    out_d = out_q;
    if (!pwr_n) begin
      frm_d = '0;
      out_d = 1'b0;
    end else if (bit_en) begin
      unique case (kind)
        SK_LEAD: begin
          frm_d = cap;
          out_d = 1'b0;
        end
        SK_DATA: out_d = frm_q[data_idx];
        SK_TAIL: out_d = ~frm_q[DATA_W-1];
        default: out_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= '0;
      out_q <= 1'b0;
    end else begin
      frm_q <= frm_d;
      out_q <= out_d;
    end
  end

  assign sdo = out_q;

  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && kind == SK_LEAD) |=> !out_q); // R2
  AST_TAIL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && kind == SK_TAIL) |=> (out_q == ~frm_q[DATA_W-1])); // R4
  AST_FRAME_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && kind == SK_LEAD) |=> (frm_q == $past(cap))); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && !bit_en) |=> $stable(out_q)); // R5
endmodule

// File: rtl/word_framer_ser.sv
module word_framer_ser
  import sf_pkg::*;
#(
  parameter int DATA_W      = 22,
  parameter int TAIL_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_n,
  input  logic              bit_en,
  input  logic              word_ld,
  input  logic [DATA_W-1:0] din,
  output logic              sdo
);
  localparam int IDX_W = $clog2(DATA_W);

  logic              rst_sync_n;
  logic [DATA_W-1:0] cap;
  slot_kind_e        kind;
  logic [IDX_W-1:0]  data_idx;

  sf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  sf_word_latch #(.DATA_W(DATA_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pwr_n (pwr_n),
    .ld    (word_ld),
    .din   (din),
    .cap   (cap)
  );

  sf_slot_seq #(.DATA_W(DATA_W), .TAIL_W(TAIL_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pwr_n    (pwr_n),
    .bit_en   (bit_en),
    .kind     (kind),
    .data_idx (data_idx)
  );

  sf_bit_mux #(.DATA_W(DATA_W)) u_mux (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pwr_n    (pwr_n),
    .bit_en   (bit_en),
    .kind     (kind),
    .data_idx (data_idx),
    .cap      (cap),
    .sdo      (sdo)
  );

  AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pwr_n |=> !sdo); // R6
  AST_RST_IDLE: assert property (@(posedge clk)
    !rst_sync_n |-> !sdo); // R9
endmodule

// File: tb/test_word_framer_ser.sv
`timescale 1ns/1ps
module test_word_framer_ser;
  localparam int DW    = 22;
  localparam int FLEN  = 25;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pwr_n;
  logic          bit_en;
  logic          word_ld;
  logic [DW-1:0] din;
  logic          sdo;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  int            m_slot;
  logic [DW-1:0] m_cap;
  logic [DW-1:0] m_frm;
  logic          m_out;
  bit            m_first;

  always #2.5 clk = ~clk;

  word_framer_ser i_word_framer_ser (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .bit_en(bit_en),
    .word_ld(word_ld), .din(din), .sdo(sdo)
  );

  // Slot content from R2, R3 and R4
  function automatic logic exp_bit(int slot, logic [DW-1:0] w);
    if (slot == 0)       return 1'b0;
    else if (slot <= DW) return w[slot-1];
    else                 return ~w[DW-1];
  endfunction

  task automatic chk(logic act, logic exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: sdo=%0b expected %0b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic pw, logic en, logic ld, logic [DW-1:0] d);
    string tag;
    @(negedge clk);
    pwr_n = pw; bit_en = en; word_ld = ld; din = d;
    @(posedge clk);
    if (!pw) begin
      m_out = 1'b0; m_slot = 0; m_cap = '0; m_frm = '0; m_first = 1'b1;
      tag = "R6";
    end else begin
      if (en) begin
        if (m_slot == 0) m_frm = m_cap;
        m_out = exp_bit(m_slot, m_frm);
        if (m_first)          tag = "R8 R2";
        else if (m_slot == 0) tag = "R2";
        else if (m_slot <= DW) tag = "R1 R3 R7";
        else                  tag = "R4";
        m_first = 1'b0;
        m_slot  = (m_slot == FLEN-1) ? 0 : m_slot + 1;
      end else begin
        tag = "R5";
      end
      if (ld) m_cap = d;
    end
    #1;
    chk(sdo, m_out, tag);
  endtask

  task automatic send_frame(logic [DW-1:0] w);
    for (int i = 0; i < FLEN; i++) step(1'b1, 1'b1, i == 10, w);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pwr_n = 1'b0; bit_en = 1'b0; word_ld = 1'b0; din = '0;
    m_slot = 0; m_cap = '0; m_frm = '0; m_out = 1'b0; m_first = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk(sdo, 1'b0, "R9");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk(sdo, 1'b0, "R9");
    // Directed: first frame after power-up carries the cleared word
    send_frame(22'h3FFFFF);
    send_frame(22'h000000);
    send_frame(22'h200000);
    send_frame(22'h155555);
    send_frame(22'h0ABCDE);
    // Capture on the slot-0 edge itself (R7)
    for (int i = 0; i < FLEN; i++) step(1'b1, 1'b1, i == 0, 22'h2AAAAA);
    for (int i = 0; i < 2*FLEN; i++) step(1'b1, 1'b1, 1'b0, '0);
    // Power-down mid-frame with a capture pulsed during it (R6)
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 1'b1, 22'h3FFFFF);
    step(1'b0, 1'b0, 1'b1, 22'h1F0F0F);
    for (int i = 0; i < 2*FLEN; i++) step(1'b1, 1'b1, 1'b0, '0);
    // Constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic pw, en, ld;
      pw = ($urandom % 400) != 0;
      en = ($urandom % 4) != 0;
      ld = ($urandom % 28) == 0;
      step(pw, en, ld, DW'($urandom));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule